// File: doc/BRIEF.md
# One-Entry Pipeline FIFO

This block is a single-slot queue placed between two pipeline stages. The producer offers a word with `push_req`, and the word is taken in any cycle where `push_ok` is high. The consumer sees the held word on `head_data` while `head_vld` is high. It retires the word with `pop_req`. A `flush_req` input empties the slot whatever its state.

Inside one clock cycle the operations follow a fixed order. The head is read first. A pop or a flush acts next, and a push acts last. The push side therefore sees the slot as already vacated by a same-cycle pop or flush. A full slot can hand off its word and accept a new one in the same cycle, so a stream passes at one word per clock with no bubble.

The occupancy flag and the payload are each held in an ordered-port register. Each port of such a register observes the writes of all lower-numbered ports in the same cycle, and the highest write wins at the edge. Reset is asserted asynchronously and released through a short synchronizer.

Top module: `pipe_fifo1`

## Requirements
- R1: After reset the slot is empty: `head_vld` is 0 and `push_ok` is 1.
- R2: A push accepted on an empty slot makes `head_vld` 1 on the next cycle, and `head_data` then equals the pushed word.
- R3: While the slot is full and neither pop nor flush is requested, `push_ok` is 0. A push in that cycle is ignored, so `head_vld` stays 1 and `head_data` keeps the old word.
- R4: A pop on a full slot, with no push in the same cycle, leaves the slot empty on the next cycle.
- R5: When pop and push are requested in the same cycle on a full slot, `push_ok` is 1 in that cycle. On the next cycle the slot is full and holds the new word.
- R6: Flush empties the slot on the next cycle when no push is accepted alongside it. A flush on an empty slot leaves it empty.
- R7: When flush and push are requested together, the push wins and the slot ends the cycle full with the pushed word.
- R8: `head_data` always shows the word held at the start of the cycle and never shows a same-cycle pushed word.
- R9: A pop on an empty slot is ignored: the slot stays empty and `push_ok` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_data | input | W | Word offered by the producer |
| push_req | input | 1 | Producer asks to push |
| push_ok | output | 1 | Slot can take a push this cycle (after any same-cycle pop or flush) |
| head_data | output | W | Word held in the slot |
| head_vld | output | 1 | Slot is full |
| pop_req | input | 1 | Consumer retires the held word |
| flush_req | input | 1 | Empty the slot unconditionally |

## Verification
The bench targets the same-cycle combinations on a full slot. Pop with push must not lose a cycle; a design with the plain ordering would drop `push_ok` and stall the stream. Flush with push must keep the new word, where a reversed priority would end the cycle empty. The bench also checks that `head_data` never takes a same-cycle pushed word, which would show up as a value arriving one cycle early. Pushes into a full slot with no pop must leave the held word intact, and pops on an empty slot must not create a phantom entry.

// File: rtl/fifo1_pkg.sv
package fifo1_pkg;
  // Port order inside one cycle: lower index acts first.
  localparam int P_RETIRE = 0;  // pop or flush
  localparam int P_FILL   = 1;  // push
  localparam int N_PORTS  = 2;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ord_reg.sv
// Register with NP ordered write ports. Port i reads the value after the
// writes of ports 0..i-1 this cycle; the highest enabled write is stored.
module ord_reg #(
  parameter int W      = 8,
  parameter int NP     = 2,
  parameter bit HAS_RST = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        wr_en,
  input  logic [NP-1:0][W-1:0] wr_val,
  output logic [NP-1:0][W-1:0] rd
);
  logic [W-1:0]            cur_q;
  logic [NP:0][W-1:0]      chain;
  logic                    ld_en;

  assign chain[0] = cur_q;

  generate
    for (genvar i = 0; i < NP; i++) begin : g_port
      assign chain[i+1] = wr_en[i] ? wr_val[i] : chain[i];
      assign rd[i]      = chain[i];
    end
  endgenerate

  assign ld_en = |wr_en;

  generate
    if (HAS_RST) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cur_q <= RST_VAL;
        else if (ld_en) cur_q <= chain[NP];
      end
    end else begin : g_nrst
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
        if (ld_en) cur_q <= chain[NP];
      end
    end
  endgenerate
endmodule

// File: rtl/pipe_fifo1.sv
module pipe_fifo1
  import fifo1_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] push_data,
  input  logic         push_req,
  output logic         push_ok,
  output logic [W-1:0] head_data,
  output logic         head_vld,
  input  logic         pop_req,
  input  logic         flush_req
);
  logic                      rst_ok_n;
  logic [N_PORTS-1:0]        occ_we;
  logic [N_PORTS-1:0][0:0]   occ_wv;
  logic [N_PORTS-1:0][0:0]   occ_rd;
  logic [N_PORTS-1:0]        dat_we;
  logic [N_PORTS-1:0][W-1:0] dat_wv;
  logic [N_PORTS-1:0][W-1:0] dat_rd;
  logic                      retire;
  logic                      fill;
  logic [W-1:0]              unused_dat;

  rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_ok_n)
  );

  // Next-state decisions, in port order.
  always_comb begin
    retire = flush_req | (pop_req & occ_rd[P_RETIRE][0]);
    fill   = push_req & ~occ_rd[P_FILL][0];

    occ_we             = '0;
    occ_wv             = '0;
    occ_we[P_RETIRE]   = retire;
    occ_wv[P_RETIRE]   = 1'b0;
    occ_we[P_FILL]     = fill;
    occ_wv[P_FILL]     = 1'b1;

    dat_we             = '0;
    dat_wv             = '0;
    dat_we[P_FILL]     = fill;
    dat_wv[P_FILL]     = push_data;
  end

  ord_reg #(.W(1), .NP(N_PORTS), .HAS_RST(1'b1), .RST_VAL(1'b0)) u_occ (
    .clk(clk), .rst_n(rst_ok_n), .wr_en(occ_we), .wr_val(occ_wv), .rd(occ_rd)
  );

  ord_reg #(.W(W), .NP(N_PORTS), .HAS_RST(1'b0), .RST_VAL('0)) u_dat (
    .clk(clk), .rst_n(rst_ok_n), .wr_en(dat_we), .wr_val(dat_wv), .rd(dat_rd)
  );

  assign head_vld   = occ_rd[P_RETIRE][0];
  assign head_data  = dat_rd[P_RETIRE];
  assign push_ok    = ~occ_rd[P_FILL][0];
  assign unused_dat = dat_rd[P_FILL];
endmodule

// File: rtl/pipe_fifo1_chk.sv
module pipe_fifo1_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] push_data,
  input logic         push_req,
  input logic         push_ok,
  input logic [W-1:0] head_data,
  input logic         head_vld,
  input logic         pop_req,
  input logic         flush_req
);
  assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && push_ok) |=> (head_vld && head_data == $past(push_data)));

  assert_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && !pop_req && !flush_req) |-> !push_ok);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && !pop_req && !flush_req) |=> (head_vld && $stable(head_data)));

  assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pop_req || flush_req) && !push_req) |=> !head_vld);

  assert_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (head_vld && (pop_req || flush_req)) |-> push_ok);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_vld && !push_req) |=> (!head_vld && push_ok));
endmodule

bind pipe_fifo1 pipe_fifo1_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_ok_n), .push_data(push_data), .push_req(push_req),
  .push_ok(push_ok), .head_data(head_data), .head_vld(head_vld),
  .pop_req(pop_req), .flush_req(flush_req)
);

// File: tb/sim_pipe_fifo1.sv
module sim_pipe_fifo1;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] push_data = '0;
  logic         push_req = 1'b0;
  logic         pop_req = 1'b0;
  logic         flush_req = 1'b0;
  logic         push_ok;
  logic [W-1:0] head_data;
  logic         head_vld;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [W-1:0] mq[$];

  always #4 clk = ~clk;  // 125 MHz

  pipe_fifo1 #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .push_data(push_data), .push_req(push_req),
    .push_ok(push_ok), .head_data(head_data), .head_vld(head_vld),
    .pop_req(pop_req), .flush_req(flush_req)
  );

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive, compare against the reference, then advance the model.
  task automatic step(string tag, bit pu, logic [W-1:0] d, bit po, bit fl);
    bit exp_ok;
    @(negedge clk);
    push_req = pu; push_data = d; pop_req = po; flush_req = fl;
    #1;
    exp_ok = (mq.size() == 0) || fl || po;
    check(tag, "head_vld", W'(head_vld), W'(mq.size() != 0));
    if (mq.size() != 0) check(tag, "head_data", head_data, mq[0]);
    check(tag, "push_ok", W'(push_ok), W'(exp_ok));
    @(posedge clk);
    if (fl || (po && mq.size() != 0)) mq.delete();
    if (pu && exp_ok) mq.push_back(d);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1 reset state
    step("R1", 0, 8'h00, 0, 0);
    // R9 pop on empty ignored
    step("R9", 0, 8'h00, 1, 0);
    step("R9", 0, 8'h00, 0, 0);
    // R2 fill
    step("R2", 1, 8'hA1, 0, 0);
    // R3 push into full ignored; R8 head holds old word
    step("R3", 1, 8'hB2, 0, 0);
    step("R3", 0, 8'h00, 0, 0);
    // R5 pop + push same cycle, R8 head not updated early
    step("R5", 1, 8'hC3, 1, 0);
    step("R8", 1, 8'hD4, 1, 0);
    step("R5", 0, 8'h00, 0, 0);
    // R4 pop drains
    step("R4", 0, 8'h00, 1, 0);
    step("R4", 0, 8'h00, 0, 0);
    // R6 flush on empty and full
    step("R6", 0, 8'h00, 0, 1);
    step("R6", 1, 8'h5E, 0, 0);
    step("R6", 0, 8'h00, 0, 1);
    step("R6", 0, 8'h00, 0, 0);
    // R7 flush + push on full and on empty
    step("R7", 1, 8'h11, 0, 0);
    step("R7", 1, 8'h22, 0, 1);
    step("R7", 0, 8'h00, 0, 0);
    step("R7", 0, 8'h00, 0, 1);
    step("R7", 1, 8'h33, 0, 1);
    step("R7", 0, 8'h00, 0, 0);
    // Streaming at full rate (R5)
    for (int i = 0; i < 20; i++) step("R5", 1, W'(8'h40 + i), 1, 0);
    // Pseudo-random mix (R2 R3 R4 R6 R7 R9)
    for (int i = 0; i < 400; i++) begin
      int r = (i * 37 + 11) % 97;
      step("R8", r[0], W'(i * 13), r[1] & r[2], (r % 11) == 0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule